// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Controller

This block is the interrupt front end of a four-channel timer peripheral on an 8-bit bus with multiplexed opcode fetch and interrupt acknowledge cycles. Each channel presents a one-cycle terminal-count pulse. The pulse becomes a pending request when that channel's interrupt enable is set. The block ranks pending requests by channel number and answers an acknowledge cycle with a vectored-mode byte. The byte is built from a programmed base and the number of the winning channel. The block then records which channels are being serviced.

Priority between chips is carried by an enable-in and enable-out pair. The enable-in tells the block that no upstream device is claiming the bus. The enable-out passes that permission downstream only while this block has nothing in service. Service never ends through a register write. The block watches opcode fetches on the data bus for the two-byte return-from-interrupt sequence and releases its highest-priority in-service channel when that sequence is seen.

All bus strobes are active low and are sampled on the block clock. Tri-state is modelled as a separate data output and output enable.

Top module: `irq_chain_ctrl`

## Requirements
- R1: Channel 0 has the highest priority and channel 3 the lowest. When several eligible channels are pending at an acknowledge, the lowest-numbered one is answered.
- R2: The vector byte has the programmed base in bits 7..3, the binary number of the answered channel in bits 2..1, and 0 in bit 0.
- R3: An acknowledge cycle is m1_n=0, iorq_n=0 and rd_n=1. A vector is supplied only if iei is high in the first cycle of that acknowledge. data_oe is high only while that acknowledge lasts, and data_out is 0 whenever data_oe is low.
- R4: A cycle with rd_n=0, which is an opcode fetch, never drives the bus, even with requests pending.
- R5: Pending requests are frozen while m1_n=0. An enabled pulse that arrives then is held back and becomes pending once m1_n returns high, so the acknowledge in progress cannot answer it.
- R6: A channel in service blocks that channel and every lower-priority channel from being answered. A higher-priority channel can still be answered, which gives nested service.
- R7: ieo is high only when iei is high and no channel is in service. In addition, ieo is forced low while m1_n=0 and any request is pending.
- R8: An opcode fetch of 8'hED with iei high, followed directly by an opcode fetch of 8'h4D, releases the highest-priority in-service channel.
- R9: Any other opcode fetched directly after 8'hED resets the sequence detector, and so does an 8'hED fetched with iei low. Neither releases a channel.
- R10: A terminal-count pulse on a channel whose enable input is low is ignored.
- R11: Supplying a vector clears that channel's pending request and marks the channel in service, in the same acknowledge.
- R12: Reset clears all pending requests, all in-service marks and the sequence detector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tc_pulse | input | 4 | One-cycle terminal-count pulse per channel |
| irq_en | input | 4 | Interrupt enable per channel |
| vec_base | input | 5 | Programmed upper bits of the vector |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_in | input | 8 | Data bus as seen by the block (opcode snooping) |
| iei | input | 1 | Daisy-chain enable from the upstream device |
| ieo | output | 1 | Daisy-chain enable to the downstream device |
| data_out | output | 8 | Vector byte while data_oe is high, otherwise 0 |
| data_oe | output | 1 | Data bus drive enable |

## Verification
Nested service is exercised with a low channel in service and both a lower and a higher channel pending. A design that masked wrongly would either answer the lower channel or refuse the higher one. Return sequences are sent whole, broken by a stray opcode, and started with iei low. A detector that did not reset would release a channel on a late 8'h4D. A pulse that lands inside an acknowledge must not be answered by it but must be answered by the next acknowledge, so a design without the freeze shows up in the first cycle and one that drops the pulse shows up in the second. Disabled channels, acknowledges with iei low, fetch cycles with requests pending, and reset in the middle of service each check that nothing is driven or released where it should not be.

// File: rtl/icc_pkg.sv
// Package: shared constants and types for the daisy-chain interrupt controller.
// Assumes the channel count is a power of two so the channel number fills
// the vector field exactly.
package icc_pkg;

    // Opcode bytes that make up the return-from-interrupt sequence.
    localparam logic [7:0] RET_LEAD  = 8'hED;
    localparam logic [7:0] RET_TRAIL = 8'h4D;

    // States of the return-sequence detector.
    typedef enum logic {
        RS_IDLE,
        RS_LEAD
    } ret_state_t;

endpackage

// File: rtl/icc_request.sv
// Module: icc_request
// Collects terminal-count pulses into pending requests, one bit per channel.
// Assumes pulses are synchronous to clk. While m1_low is set, the pending
// bits may only be cleared; new arrivals wait in a side register and are
// merged once m1_low drops. Clears from the arbiter come only during M1.
module icc_request #(
    parameter int CH_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] tc_pulse,
    input  logic [CH_N-1:0] irq_en,
    input  logic            m1_low,
    input  logic [CH_N-1:0] clr_mask,
    output logic [CH_N-1:0] pend
);

    logic [CH_N-1:0] arrive;
    logic [CH_N-1:0] held;

    // Keep only pulses from enabled channels.
    always_comb begin
        arrive = tc_pulse & irq_en;
    end

    // Update the pending and held-back bits, with the freeze during M1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            held <= '0;
        end else if (m1_low) begin
            pend <= pend & ~clr_mask;
            held <= held | arrive;
        end else begin
            pend <= (pend | held | arrive) & ~clr_mask;
            held <= '0;
        end
    end

endmodule

// File: rtl/icc_service.sv
// Module: icc_service
// Selects the channel to answer and keeps the in-service bits.
// Assumes take and release never arrive in the same cycle, because an
// acknowledge and an opcode fetch are mutually exclusive bus cycles.
// A channel is eligible when it is pending and neither it nor any channel
// of higher priority (a lower index) is in service.
module icc_service #(
    parameter int CH_N = 4,
    localparam int CW  = $clog2(CH_N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] pend,
    input  logic            take,
    input  logic            release_one,
    output logic            hit,
    output logic [CW-1:0]   sel_ch,
    output logic [CH_N-1:0] clr_mask,
    output logic [CH_N-1:0] ins
);

    logic [CH_N-1:0] blocked;
    logic [CH_N-1:0] elig;
    logic [CH_N-1:0] sel_hot;
    logic [CH_N-1:0] rel_hot;

    // blocked[c] is set when channel c or any higher-priority channel is in service.
    for (genvar c = 0; c < CH_N; c++) begin : g_block
        assign blocked[c] = |ins[c:0];
    end

    // Eligible requests and whether any exist.
    always_comb begin
        elig = pend & ~blocked;
        hit  = |elig;
    end

    // Lowest-index eligible channel, as number and one-hot.
    always_comb begin
        sel_ch  = '0;
        sel_hot = '0;
        for (int c = CH_N - 1; c >= 0; c--) begin
            if (elig[c]) begin
                sel_ch  = CW'(c);
                sel_hot = CH_N'(1) << c;
            end
        end
    end

    // Lowest-index in-service channel, which is the one a return releases.
    always_comb begin
        rel_hot = '0;
        for (int c = CH_N - 1; c >= 0; c--) begin
            if (ins[c]) begin
                rel_hot = CH_N'(1) << c;
            end
        end
    end

    // Pending bit to clear when a vector is taken.
    always_comb begin
        clr_mask = take ? sel_hot : '0;
    end

    // Set a bit on a take, clear the top-priority bit on a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins <= '0;
        end else if (take) begin
            ins <= ins | sel_hot;
        end else if (release_one) begin
            ins <= ins & ~rel_hot;
        end
    end

endmodule

// File: rtl/icc_ret_detect.sv
// Module: icc_ret_detect
// Watches opcode fetches for the two-byte return sequence.
// Assumes fetch_start is high for exactly one cycle per fetch, in the first
// cycle, and that data_in holds the opcode in that cycle. The lead byte is
// accepted only while iei is high. Any fetch after the lead byte sends the
// detector back to idle.
module icc_ret_detect
    import icc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fetch_start,
    input  logic [7:0] data_in,
    input  logic       iei,
    output logic       release_one
);

    ret_state_t st;
    ret_state_t st_nx;

    // Next state and the release pulse.
    always_comb begin
        st_nx       = st;
        release_one = 1'b0;
        if (fetch_start) begin
            unique case (st)
                RS_IDLE: begin
                    if (data_in == RET_LEAD && iei) begin
                        st_nx = RS_LEAD;
                    end
                end
                RS_LEAD: begin
                    st_nx       = RS_IDLE;
                    release_one = (data_in == RET_TRAIL);
                end
                default: st_nx = RS_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RS_IDLE;
        end else begin
            st <= st_nx;
        end
    end

endmodule

// File: rtl/irq_chain_ctrl.sv
// Module: irq_chain_ctrl (top)
// Daisy-chain interrupt priority controller for a four-channel peripheral.
// Assumes the bus strobes are synchronous to clk. The vector is taken in
// the first sampled cycle of an acknowledge and is driven from the next
// cycle until the acknowledge ends. ieo is combinational from iei, m1_n and
// internal state so the chain settles within a cycle.
module irq_chain_ctrl #(
    parameter int  CH_N = 4,
    localparam int CW   = $clog2(CH_N),
    localparam int BW   = 7 - CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CH_N-1:0] tc_pulse,
    input  logic [CH_N-1:0] irq_en,
    input  logic [BW-1:0]   vec_base,
    input  logic            m1_n,
    input  logic            iorq_n,
    input  logic            rd_n,
    input  logic [7:0]      data_in,
    input  logic            iei,
    output logic            ieo,
    output logic [7:0]      data_out,
    output logic            data_oe
);

    logic            m1_low;
    logic            ack_now;
    logic            fetch_now;
    logic            ack_q;
    logic            fetch_q;
    logic            take;
    logic            grant_q;
    logic [CW-1:0]   vec_ch;
    logic [CH_N-1:0] pend;
    logic [CH_N-1:0] ins;
    logic [CH_N-1:0] clr_mask;
    logic            hit;
    logic [CW-1:0]   sel_ch;
    logic            release_one;

    // Decode the bus cycle type from the strobes.
    always_comb begin
        m1_low    = !m1_n;
        ack_now   = m1_low && !iorq_n && rd_n;
        fetch_now = m1_low && !rd_n && iorq_n;
    end

    // Remember the previous cycle type so that starts can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            ack_q   <= ack_now;
            fetch_q <= fetch_now;
        end
    end

    // Answer at the start of an acknowledge if the chain allows it.
    always_comb begin
        take = ack_now && !ack_q && iei && hit;
    end

    // Hold the drive window and the chosen channel number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            vec_ch  <= '0;
        end else if (!ack_now) begin
            grant_q <= 1'b0;
        end else if (take) begin
            grant_q <= 1'b1;
            vec_ch  <= sel_ch;
        end
    end

    // Data bus drive and vector assembly.
    always_comb begin
        data_oe  = grant_q && ack_now;
        data_out = data_oe ? {vec_base, vec_ch, 1'b0} : 8'h00;
    end

    // Pass the chain enable downstream.
    always_comb begin
        ieo = iei && (ins == '0) && !(m1_low && (pend != '0));
    end

    icc_request #(.CH_N(CH_N)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_pulse (tc_pulse),
        .irq_en   (irq_en),
        .m1_low   (m1_low),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    icc_service #(.CH_N(CH_N)) u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend),
        .take        (take),
        .release_one (release_one),
        .hit         (hit),
        .sel_ch      (sel_ch),
        .clr_mask    (clr_mask),
        .ins         (ins)
    );

    icc_ret_detect u_ret (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_start (fetch_now && !fetch_q),
        .data_in     (data_in),
        .iei         (iei),
        .release_one (release_one)
    );

endmodule

// File: rtl/irq_chain_ctrl_chk.sv
// Module: irq_chain_ctrl_chk
// Property checker for irq_chain_ctrl, attached with the bind below.
// Assumes nothing beyond the top module's ports and its pend/ins state.
module irq_chain_ctrl_chk #(
    parameter int  CH_N = 4,
    localparam int CW   = $clog2(CH_N),
    localparam int BW   = 7 - CW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            m1_n,
    input logic            iorq_n,
    input logic            rd_n,
    input logic            iei,
    input logic            ieo,
    input logic [BW-1:0]   vec_base,
    input logic [7:0]      data_out,
    input logic            data_oe,
    input logic [CH_N-1:0] pend,
    input logic [CH_N-1:0] ins
);

    logic armed;

    // Set once a clock edge has passed out of reset, so that $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    // R3: the bus is driven only inside an acknowledge cycle.
    p_drive_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!m1_n && !iorq_n && rd_n));

    // R4: never drive the bus during a read.
    p_no_drive_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !data_oe);

    // R2: vector format.
    p_vec_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out[0] == 1'b0 && data_out[7:8-BW] == vec_base));

    // R7: the chain enable passes only with iei high and nothing in service.
    p_ieo_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ieo |-> (iei && ins == '0));

    // R5: no new pending bit appears while M1 stays low.
    p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !m1_n && $past(!m1_n)) |-> ((pend & ~$past(pend)) == '0));

    // R11: the channel named in a new vector has just entered service.
    p_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(data_oe)) |-> (ins[data_out[CW:1]] && !$past(ins[data_out[CW:1]])));

    // R6: at most one channel enters service per cycle.
    p_one_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ($countones(ins & ~$past(ins)) <= 1));

endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.CH_N(CH_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .m1_n     (m1_n),
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .iei      (iei),
    .ieo      (ieo),
    .vec_base (vec_base),
    .data_out (data_out),
    .data_oe  (data_oe),
    .pend     (pend),
    .ins      (ins)
);

// File: tb/irq_chain_ctrl_test.sv
// Bench for irq_chain_ctrl: the acknowledge driver pushes the expected bus
// result into a queue, and a monitor pops it when the sample point arrives.
module irq_chain_ctrl_test;

    localparam int PERIOD = 10;

    typedef struct {
        logic [8:0] val;   // {drive, byte}
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tc_pulse = '0;
    logic [3:0] irq_en = 4'hF;
    logic [4:0] vec_base = 5'h15;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       iei = 1'b1;
    logic       ieo;
    logic [7:0] data_out;
    logic       data_oe;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    event smp_ev;

    irq_chain_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_pulse (tc_pulse),
        .irq_en   (irq_en),
        .vec_base (vec_base),
        .m1_n     (m1_n),
        .iorq_n   (iorq_n),
        .rd_n     (rd_n),
        .data_in  (data_in),
        .iei      (iei),
        .ieo      (ieo),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pop the expected bus result and compare with what is seen.
    initial begin
        forever begin
            @(smp_ev);
            if (sb.size() == 0) begin
                check("queue underrun", {data_oe, data_out}, 9'h1FF);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {data_oe, data_out}, e.val);
            end
        end
    end

    task automatic pulse(input logic [3:0] m);
        @(negedge clk); tc_pulse = m;
        @(negedge clk); tc_pulse = '0;
        @(negedge clk);
    endtask

    // Acknowledge cycle; mid is a pulse applied while M1 is already low.
    task automatic ack(input logic [8:0] exp, input string tag, input logic [3:0] mid);
        exp_t e;
        e.val = exp;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk); m1_n = 1'b0; rd_n = 1'b1;
        @(negedge clk); tc_pulse = mid;
        @(negedge clk); tc_pulse = '0; iorq_n = 1'b0;
        @(negedge clk); #1 -> smp_ev;
        #1 m1_n = 1'b1; iorq_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fetch(input logic [7:0] b);
        @(negedge clk); m1_n = 1'b0; rd_n = 1'b0; data_in = b;
        @(negedge clk); m1_n = 1'b1; rd_n = 1'b1; data_in = 8'h00;
        @(negedge clk);
    endtask

    // M1 low with no IORQ and no read: report ieo while it is held.
    task automatic m1_probe(output logic v);
        @(negedge clk); m1_n = 1'b0;
        #1 v = ieo;
        @(negedge clk); m1_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        logic v;
        do_reset();
        // R12: reset state
        check("R12 ieo after reset", {8'h0, ieo}, 9'h001);
        check("R12 no drive after reset", {data_oe, data_out}, 9'h000);

        // R2 R11: single request on channel 2, vector {10101,10,0}
        pulse(4'b0100);
        ack({1'b1, 8'hAC}, "R2 R11 ch2 vector", 4'h0);
        check("R7 ieo low while ch2 in service", {8'h0, ieo}, 9'h000);

        // R6: ch3 blocked by ch2 in service; ch0 nests above it
        pulse(4'b1000);
        ack(9'h000, "R6 lower ch3 blocked", 4'h0);
        pulse(4'b0001);
        ack({1'b1, 8'hA8}, "R6 higher ch0 nests", 4'h0);

        // R8: first return releases ch0, second releases ch2
        fetch(8'hED); fetch(8'h4D);
        check("R8 ch2 still in service", {8'h0, ieo}, 9'h000);
        fetch(8'hED); fetch(8'h4D);
        check("R7 ieo high with ch3 pending and M1 high", {8'h0, ieo}, 9'h001);
        m1_probe(v);
        check("R7 ieo forced low in M1 with pending", {8'h0, v}, 9'h000);
        vec_base = 5'h0A;
        ack({1'b1, 8'h56}, "R2 ch3 vector with new base", 4'h0);
        vec_base = 5'h15;

        // R9: broken sequence does not release
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        check("R9 stray byte resets detector", {8'h0, ieo}, 9'h000);
        iei = 1'b0; fetch(8'hED); iei = 1'b1; fetch(8'h4D);
        check("R9 lead byte with iei low ignored", {8'h0, ieo}, 9'h000);
        fetch(8'hED); fetch(8'h4D);
        check("R8 full sequence releases ch3", {8'h0, ieo}, 9'h001);

        // R10: disabled channel ignored
        irq_en = 4'b1101;
        pulse(4'b0010);
        ack(9'h000, "R10 disabled ch1 ignored", 4'h0);
        irq_en = 4'hF;

        // R3: iei low blocks the vector; request stays pending
        pulse(4'b0010);
        iei = 1'b0;
        ack(9'h000, "R3 no drive with iei low", 4'h0);
        iei = 1'b1;
        ack({1'b1, 8'hAA}, "R3 ch1 answered once iei high", 4'h0);
        fetch(8'hED); fetch(8'h4D);

        // R4: read cycle with iorq low and a request pending never drives
        pulse(4'b0001);
        @(negedge clk); m1_n = 1'b0; rd_n = 1'b0; iorq_n = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        check("R4 no drive when rd_n low", {data_oe, data_out}, 9'h000);
        m1_n = 1'b1; rd_n = 1'b1; iorq_n = 1'b1;
        @(negedge clk);
        ack({1'b1, 8'hA8}, "R4 ch0 still pending", 4'h0);
        fetch(8'hED); fetch(8'h4D);

        // R5: pulse during M1 is not answered now but is held for later
        ack(9'h000, "R5 pulse in M1 not answered", 4'b0010);
        ack({1'b1, 8'hAA}, "R5 held pulse answered next", 4'h0);
        fetch(8'hED); fetch(8'h4D);

        // R1: simultaneous ch1 and ch3, ch1 wins
        pulse(4'b1010);
        ack({1'b1, 8'hAA}, "R1 ch1 beats ch3", 4'h0);
        fetch(8'hED); fetch(8'h4D);
        ack({1'b1, 8'hAE}, "R1 ch3 after ch1", 4'h0);

        // R12: reset in the middle of service clears everything
        pulse(4'b0001);
        do_reset();
        check("R12 ieo after mid reset", {8'h0, ieo}, 9'h001);
        ack(9'h000, "R12 pending cleared", 4'h0);

        repeat (2) @(negedge clk);
        if (sb.size() != 0) check("scoreboard drained", 9'(sb.size()), 9'h000);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: end a hung run as a failed check.
    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule